// File: doc/BRIEF.md
# Register-Mapped Asynchronous Serial Port

This block is a full-duplex asynchronous serial transmitter and receiver behind a small 8-bit register bus with four addresses. One data address serves both directions. A write places a character in the transmitter, and that write starts a frame. A read returns the most recently received character. A mode register selects the character length (7 or 8 bits), the parity style, and one or two stop bits. It also holds separate enables for transmit and receive. A divisor register sets the oversampling tick rate. One bit period lasts `OVS` ticks, and one tick lasts `divisor + 1` clock cycles.

The receiver synchronises the line and confirms a start bit at its middle. It then samples each data bit at its centre, least significant bit first. It checks the parity bit and the first stop bit. Each finished character is copied into the receive buffer. Parity, framing and overrun errors set sticky flags in the status register. Reading the status register clears those flags. The bus has no back-pressure. A read of the data or status address has its side effect on the clock edge where `bus_rd` is high. `bus_rdata` is combinational from `bus_addr`.

Address map: 0 = data (write: transmit, read: receive buffer), 1 = mode, 2 = status (read only), 3 = divisor. Mode bits: [0] transmit enable, [1] receive enable, [3:2] parity (00 none, 01 even, 10 odd, 11 always 0), [4] 7-bit characters, [5] two stop bits. Status bits: [0] parity error, [1] framing error, [2] overrun, [3] character ready, [4] transmitter busy.

Top module: `uart_regport`

## Requirements
- R1: When the transmitter is idle and transmit enable is set, a write to address 0 starts a frame on the edge of that write: `txd` goes low that edge. `txd` is high whenever no frame is in progress.
- R2: A frame is a low start bit, then the data bits LSB first, then the optional parity bit, then one or two high stop bits. Each bit lasts exactly 16 × (divisor + 1) clock cycles.
- R3: The parity bit makes the count of ones over the data bits and the parity bit even (mode 01) or odd (mode 10). Mode 11 sends a 0. Mode 00 sends no parity bit.
- R4: In 7-bit mode only bits 0 to 6 of the written byte are sent, and parity covers only those bits.
- R5: A read of address 0 returns the receive buffer. A write to address 0 never changes the receive buffer, including when transmit is disabled and no frame starts.
- R6: In 7-bit mode the received character fills buffer bits 0 to 6, and bit 7 reads 0.
- R7: A write to address 0 while a frame is in progress is ignored. The frame continues unchanged and no second frame follows.
- R8: A received parity bit that does not match the selected parity mode sets status bit 0.
- R9: A first stop bit sampled low sets status bit 1.
- R10: A character completed while status bit 3 (ready) is still set sets status bit 2. Reading address 0 clears status bit 3.
- R11: Reading address 2 clears status bits 0 to 2.
- R12: After reset, `txd` is high, mode reads 0, status reads 0 and the divisor reads `DIV_INIT`.
- R13: The mode and divisor registers read back the values written to them. A divisor of 1 doubles every bit time compared with a divisor of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; read side effects happen on this edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line, asynchronous |

## Verification
The transmit line is registered, and the tick counter restarts on the accepting write. Frame bit `k` is therefore on `txd` from `16·(d+1)·k` cycles after the write edge until the next boundary. The bench compares `txd` against its expected bit queue at every falling edge of the frame. Received characters and flags take a two-flop synchroniser plus half a bit to start, then one bit per character bit. For that reason the bench reads the data and status registers only after the last stop bit has fully ended. Each read samples `bus_rdata` before the edge that applies the read's clearing effect.

// File: rtl/uart_rp_pkg.sv
package uart_rp_pkg;
  typedef enum logic [1:0] {
    PAR_NONE = 2'b00,
    PAR_EVEN = 2'b01,
    PAR_ODD  = 2'b10,
    PAR_ZERO = 2'b11
  } par_e;

  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_MODE = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;
  localparam logic [1:0] A_DIV  = 2'd3;

  function automatic logic parity_of(input par_e m, input logic [7:0] d);
    case (m)
      PAR_EVEN: parity_of = ^d;
      PAR_ODD:  parity_of = ~(^d);
      default:  parity_of = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/uart_rp_baud.sv
module uart_rp_baud #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = (cnt >= div);

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (clr || tick)  cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/uart_rp_tx.sv
module uart_rp_tx
  import uart_rp_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       en,
  input  logic       len7,
  input  par_e       par,
  input  logic       stop2,
  input  logic       ld,
  input  logic [7:0] ld_data,
  output logic       start,
  output logic       busy,
  output logic       txd
);
  localparam int SUB_W = $clog2(OVS);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);

  typedef enum logic [2:0] {T_IDLE, T_START, T_DATA, T_PAR, T_STOP} tst_e;

  tst_e             st;
  logic [7:0]       data_q;
  logic [SUB_W-1:0] sub;
  logic [2:0]       idx;
  logic             c_len7, c_stop2;
  par_e             c_par;
  logic [7:0]       eff;

  assign busy  = (st != T_IDLE);
  assign start = ld && !busy && en;
  assign eff   = c_len7 ? {1'b0, data_q[6:0]} : data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= T_IDLE;
      data_q  <= 8'hFF;
      sub     <= '0;
      idx     <= '0;
      txd     <= 1'b1;
      c_len7  <= 1'b0;
      c_stop2 <= 1'b0;
      c_par   <= PAR_NONE;
    end else if (ld && !busy) begin
      data_q <= ld_data;
      if (en) begin
        st      <= T_START;
        sub     <= '0;
        txd     <= 1'b0;
        c_len7  <= len7;
        c_stop2 <= stop2;
        c_par   <= par;
      end
    end else if (busy && tick) begin
      if (sub != SUB_LAST) begin
        sub <= sub + 1'b1;
      end else begin
        sub <= '0;
        case (st)
          T_START: begin
            st  <= T_DATA;
            idx <= '0;
            txd <= data_q[0];
          end
          T_DATA: begin
            if (idx == (c_len7 ? 3'd6 : 3'd7)) begin
              if (c_par != PAR_NONE) begin
                st  <= T_PAR;
                txd <= parity_of(c_par, eff);
              end else begin
                st  <= T_STOP;
                idx <= '0;
                txd <= 1'b1;
              end
            end else begin
              idx <= idx + 3'd1;
              txd <= data_q[idx + 3'd1];
            end
          end
          T_PAR: begin
            st  <= T_STOP;
            idx <= '0;
            txd <= 1'b1;
          end
          default: begin
            if (c_stop2 && idx == 3'd0) idx <= 3'd1;
            else                        st  <= T_IDLE;
          end
        endcase
      end
    end
  end

  a_r1_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
    (st == T_IDLE) |-> txd);
  a_r2_start_bit_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd);
  a_r7_busy_write_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ld) |=> $stable(data_q));
endmodule

// File: rtl/uart_rp_rx.sv
module uart_rp_rx
  import uart_rp_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       en,
  input  logic       len7,
  input  par_e       par,
  input  logic       rxd_raw,
  output logic       done,
  output logic [7:0] ch,
  output logic       perr,
  output logic       ferr
);
  localparam int SUB_W = $clog2(OVS);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);
  localparam logic [SUB_W-1:0] SUB_MID  = SUB_W'(OVS / 2 - 1);

  typedef enum logic [2:0] {R_IDLE, R_START, R_DATA, R_PAR, R_STOP} rst_e;

  rst_e             st;
  logic             s1, s2;
  logic [7:0]       sr;
  logic [SUB_W-1:0] sub;
  logic [2:0]       idx;
  logic             pbit, c_len7;
  par_e             c_par;

  assign ch = c_len7 ? {1'b0, sr[7:1]} : sr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= rxd_raw;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= R_IDLE;
      sr     <= '0;
      sub    <= '0;
      idx    <= '0;
      pbit   <= 1'b0;
      done   <= 1'b0;
      perr   <= 1'b0;
      ferr   <= 1'b0;
      c_len7 <= 1'b0;
      c_par  <= PAR_NONE;
    end else begin
      done <= 1'b0;
      case (st)
        R_IDLE: if (en && !s2) begin
          st     <= R_START;
          sub    <= '0;
          c_len7 <= len7;
          c_par  <= par;
        end
        R_START: if (tick) begin
          if (s2)                  st  <= R_IDLE;
          else if (sub == SUB_MID) begin
            st  <= R_DATA;
            sub <= '0;
            idx <= '0;
          end else                 sub <= sub + 1'b1;
        end
        R_DATA: if (tick) begin
          if (sub == SUB_LAST) begin
            sub <= '0;
            sr  <= {s2, sr[7:1]};
            if (idx == (c_len7 ? 3'd6 : 3'd7))
              st <= (c_par != PAR_NONE) ? R_PAR : R_STOP;
            else
              idx <= idx + 3'd1;
          end else sub <= sub + 1'b1;
        end
        R_PAR: if (tick) begin
          if (sub == SUB_LAST) begin
            sub  <= '0;
            pbit <= s2;
            st   <= R_STOP;
          end else sub <= sub + 1'b1;
        end
        default: if (tick) begin
          if (sub == SUB_LAST) begin
            sub  <= '0;
            done <= 1'b1;
            ferr <= !s2;
            perr <= (c_par != PAR_NONE) && (pbit != parity_of(c_par, ch));
            st   <= R_IDLE;
          end else sub <= sub + 1'b1;
        end
      endcase
    end
  end

  a_r6_short_char_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (done && c_len7) |-> (ch[7] == 1'b0));
endmodule

// File: rtl/uart_regport.sv
module uart_regport
  import uart_rp_pkg::*;
#(
  parameter int         OVS      = 16,
  parameter logic [7:0] DIV_INIT = 8'd53
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       txd,
  input  logic       rxd
);
  localparam int MODE_W = 6;

  logic [MODE_W-1:0] mode_q;
  logic [7:0]        div_q, rxbuf;
  logic              rdy, per, fer, ovr;
  logic              tx_tick, rx_tick, tx_start, tx_busy;
  logic              rx_done, rx_perr, rx_ferr;
  logic [7:0]        rx_ch;
  logic              wr_data, rd_data, rd_stat;
  logic              m_txen, m_rxen, m_len7, m_stop2;
  par_e              m_par;

  assign m_txen  = mode_q[0];
  assign m_rxen  = mode_q[1];
  assign m_par   = par_e'(mode_q[3:2]);
  assign m_len7  = mode_q[4];
  assign m_stop2 = mode_q[5];

  assign wr_data = bus_wr && (bus_addr == A_DATA);
  assign rd_data = bus_rd && (bus_addr == A_DATA);
  assign rd_stat = bus_rd && (bus_addr == A_STAT);

  uart_rp_baud #(.DIV_W(8)) u_tx_baud (
    .clk(clk), .rst_n(rst_n), .clr(tx_start), .div(div_q), .tick(tx_tick));

  uart_rp_baud #(.DIV_W(8)) u_rx_baud (
    .clk(clk), .rst_n(rst_n), .clr(1'b0), .div(div_q), .tick(rx_tick));

  uart_rp_tx #(.OVS(OVS)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tx_tick), .en(m_txen), .len7(m_len7),
    .par(m_par), .stop2(m_stop2), .ld(wr_data), .ld_data(bus_wdata),
    .start(tx_start), .busy(tx_busy), .txd(txd));

  uart_rp_rx #(.OVS(OVS)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(rx_tick), .en(m_rxen), .len7(m_len7),
    .par(m_par), .rxd_raw(rxd), .done(rx_done), .ch(rx_ch),
    .perr(rx_perr), .ferr(rx_ferr));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      div_q  <= DIV_INIT;
      rxbuf  <= '0;
      rdy    <= 1'b0;
      per    <= 1'b0;
      fer    <= 1'b0;
      ovr    <= 1'b0;
    end else begin
      if (bus_wr && bus_addr == A_MODE) mode_q <= bus_wdata[MODE_W-1:0];
      if (bus_wr && bus_addr == A_DIV)  div_q  <= bus_wdata;
      if (rx_done) rxbuf <= rx_ch;
      rdy <= (rdy && !rd_data) || rx_done;
      per <= (per && !rd_stat) || (rx_done && rx_perr);
      fer <= (fer && !rd_stat) || (rx_done && rx_ferr);
      ovr <= (ovr && !rd_stat) || (rx_done && rdy && !rd_data);
    end
  end

  always_comb begin
    case (bus_addr)
      A_DATA:  bus_rdata = rxbuf;
      A_MODE:  bus_rdata = {{(8-MODE_W){1'b0}}, mode_q};
      A_STAT:  bus_rdata = {3'b000, tx_busy, rdy, ovr, fer, per};
      default: bus_rdata = div_q;
    endcase
  end

  a_r10_overrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && rdy && !rd_data) |=> ovr);
  a_r11_status_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !rx_done) |=> (!per && !fer && !ovr));
  a_r5_write_keeps_buffer: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && !rx_done) |=> $stable(rxbuf));
endmodule

// File: tb/sim_uart_regport.sv
module sim_uart_regport;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       txd, rxd, drv_rxd = 1'b1, loop_en = 1'b1;
  int         nchk = 0, nerr = 0;

  assign rxd = loop_en ? txd : drv_rxd;
  always #2 clk = ~clk;

  uart_regport u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .txd(txd), .rxd(rxd));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1; #1 v = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  function automatic bit ones_odd(input logic [7:0] d, input int n);
    int c = 0;
    for (int i = 0; i < n; i++) if (d[i]) c++;
    return (c % 2) == 1;
  endfunction

  // reference: expected frame bits, then per-clock compare of txd
  task automatic tx_frame(input logic [7:0] d, input bit len7, input int par,
                          input bit stop2, input int dv, input bit inject,
                          input string req);
    bit q[$];
    int n = len7 ? 7 : 8;
    int bl = 16 * (dv + 1);
    int bad = 0, first_i = -1, act = 0, exp = 0;
    q.push_back(1'b0);
    for (int i = 0; i < n; i++) q.push_back(d[i]);
    if (par == 1) q.push_back(ones_odd(d, n));
    if (par == 2) q.push_back(!ones_odd(d, n));
    if (par == 3) q.push_back(1'b0);
    q.push_back(1'b1);
    if (stop2) q.push_back(1'b1);
    wr(2'd0, d);
    for (int i = 0; i < q.size() * bl; i++) begin
      if (txd !== q[i / bl]) begin
        bad++;
        if (first_i < 0) begin first_i = i; act = txd; exp = q[i / bl]; end
      end
      if (inject && i == 40) begin bus_addr = 2'd0; bus_wdata = 8'h3C; bus_wr = 1'b1; end
      else bus_wr = 1'b0;
      @(negedge clk);
    end
    bus_wr = 1'b0;
    check(bad == 0, req, act, exp);
    if (first_i >= 0) $display("  first mismatch at cycle %0d", first_i);
  endtask

  task automatic line_idle(input int cyc, input string req);
    int bad = 0;
    for (int i = 0; i < cyc; i++) begin
      if (txd !== 1'b1) bad++;
      @(negedge clk);
    end
    check(bad == 0, req, bad, 0);
  endtask

  task automatic send_bit(input bit b, input int cyc);
    drv_rxd = b;
    repeat (cyc) @(negedge clk);
  endtask

  task automatic rx_send(input logic [7:0] d, input int pmode, input bit bad_par,
                         input bit bad_stop);
    bit p;
    @(negedge clk);
    send_bit(1'b0, 16);
    for (int i = 0; i < 8; i++) send_bit(d[i], 16);
    if (pmode != 0) begin
      p = (pmode == 1) ? ones_odd(d, 8) : (pmode == 2) ? !ones_odd(d, 8) : 1'b0;
      send_bit(p ^ bad_par, 16);
    end
    if (bad_stop) send_bit(1'b0, 13);
    else          send_bit(1'b1, 16);
    send_bit(1'b1, 30);
  endtask

  logic [7:0] v;

  initial begin
    repeat (200000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    check(txd === 1'b1, "R12 txd after reset", txd, 1);
    rd(2'd1, v); check(v === 8'h00, "R12 mode after reset", v, 8'h00);
    rd(2'd2, v); check(v === 8'h00, "R12 status after reset", v, 8'h00);
    rd(2'd3, v); check(v === 8'd53, "R12 divisor after reset", v, 53);

    wr(2'd3, 8'd0);
    wr(2'd1, 8'h03);
    rd(2'd1, v); check(v === 8'h03, "R13 mode readback", v, 8'h03);
    rd(2'd3, v); check(v === 8'h00, "R13 divisor readback", v, 0);

    // R1 R2 8N1 frame and loopback receive
    tx_frame(8'hA5, 0, 0, 0, 0, 0, "R1 R2 8N1 frame");
    repeat (10) @(negedge clk);
    rd(2'd2, v); check(v === 8'h08, "R10 ready set after receive", v, 8'h08);
    rd(2'd0, v); check(v === 8'hA5, "R5 read returns received char", v, 8'hA5);
    rd(2'd2, v); check(v === 8'h00, "R10 ready cleared by data read", v, 8'h00);

    // R3 even parity, 1 stop
    wr(2'd1, 8'h07);
    tx_frame(8'h35, 0, 1, 0, 0, 0, "R3 even parity frame");
    repeat (10) @(negedge clk);
    rd(2'd0, v); check(v === 8'h35, "R3 even parity loopback", v, 8'h35);
    rd(2'd2, v); check(v === 8'h00, "R8 no parity error on good frame", v, 0);

    // R3 odd parity, 2 stops
    wr(2'd1, 8'h2B);
    tx_frame(8'hC1, 0, 2, 1, 0, 0, "R3 odd parity two stop frame");
    repeat (10) @(negedge clk);
    rd(2'd0, v); check(v === 8'hC1, "R3 odd parity loopback", v, 8'hC1);

    // R4 R6 7-bit, forced-zero parity
    wr(2'd1, 8'h1F);
    tx_frame(8'hD3, 1, 3, 0, 0, 0, "R4 R3 seven bit zero parity frame");
    repeat (10) @(negedge clk);
    rd(2'd0, v); check(v === 8'h53, "R6 seven bit char top bit zero", v, 8'h53);
    rd(2'd2, v); check(v === 8'h00, "R6 seven bit status clean", v, 0);

    // R7 write during frame ignored, no second frame
    wr(2'd1, 8'h03);
    tx_frame(8'h69, 0, 0, 0, 0, 1, "R7 frame unchanged by busy write");
    line_idle(60, "R7 no second frame after busy write");
    rd(2'd0, v); check(v === 8'h69, "R7 received first char only", v, 8'h69);

    // R5 write with transmit disabled leaves buffer, no frame
    wr(2'd1, 8'h02);
    wr(2'd0, 8'h11);
    line_idle(40, "R5 disabled write starts no frame");
    rd(2'd0, v); check(v === 8'h69, "R5 write keeps receive buffer", v, 8'h69);

    // R13 divisor 1 doubles bit time
    wr(2'd1, 8'h03);
    wr(2'd3, 8'd1);
    tx_frame(8'h5C, 0, 0, 0, 1, 0, "R13 R2 divisor one frame");
    repeat (20) @(negedge clk);
    rd(2'd0, v); check(v === 8'h5C, "R13 divisor one loopback", v, 8'h5C);
    wr(2'd3, 8'd0);

    // error flags with directly driven line
    loop_en = 1'b0;
    wr(2'd1, 8'h07);
    rx_send(8'h35, 1, 1, 0);
    rd(2'd2, v); check(v === 8'h09, "R8 parity error flag", v, 8'h09);
    rd(2'd0, v); check(v === 8'h35, "R8 data with parity error", v, 8'h35);
    rd(2'd2, v); check(v === 8'h00, "R11 status read cleared parity flag", v, 0);

    wr(2'd1, 8'h03);
    rx_send(8'h5A, 0, 0, 1);
    rd(2'd2, v); check(v === 8'h0A, "R9 framing error flag", v, 8'h0A);
    rd(2'd0, v); check(v === 8'h5A, "R9 data with framing error", v, 8'h5A);
    rd(2'd2, v); check(v === 8'h00, "R11 status read cleared framing flag", v, 0);

    rx_send(8'h81, 0, 0, 0);
    rx_send(8'h7E, 0, 0, 0);
    rd(2'd2, v); check(v === 8'h0C, "R10 overrun flag", v, 8'h0C);
    rd(2'd0, v); check(v === 8'h7E, "R10 buffer holds newest char", v, 8'h7E);
    rd(2'd2, v); check(v === 8'h00, "R11 status read cleared overrun", v, 0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule